// File: doc/BRIEF.md
# Per-Channel Sample Buffer with Event Flags

This block serves one lane of a multi-lane sampling front end. Converter samples of 32 bits arrive on a valid strobe and are held in a four-entry first-in first-out store. A bus reader drains them one word per read strobe. The number of words currently held is reported on a level output.

Four event conditions are tracked as sticky status bits: the store becoming full, the store becoming empty, a read attempted while empty, and a write attempted while full. Software clears a status bit by writing a one to it. Each bit has an enable bit, and the interrupt line is raised when any enabled status bit is set.

A per-lane mode input selects how the reader is told about data. With the mode bit set, a transfer request stays high while data is buffered. With the mode bit clear, only the interrupt line is used. A synchronous soft reset input returns all lane state to its power-on values.

Top module: `smpl_chan_fifo`

## Requirements
- R1: After reset the level is 0, the status bits, the enable bits, the read word, the interrupt and the transfer request are all 0.
- R2: Words leave in the order they were accepted. The read word output takes the oldest word on the clock edge that accepts a read.
- R3: The level output, which is 3 bits wide, reports from 0 to 4 words held. It updates on the same edge as the push or pop that changes it, and a push together with a pop leaves it unchanged.
- R4: A write while 4 words are held is dropped and does not change the contents. It sets status bit 3 (overflow).
- R5: A read while empty leaves the read word and the level unchanged. It sets status bit 2 (underflow).
- R6: Status bit 0 (full) is set only on the edge where the level becomes 4. Once cleared, it stays clear while the store remains full.
- R7: Status bit 1 (empty) is set only on the edge where the level falls to 0 from a nonzero value. Reset itself does not set it.
- R8: Writing a mask with the clear strobe clears the status bits marked with 1 on the second edge after the write, that is, one cycle after the write is registered. Bits marked with 0 are unaffected.
- R9: If a condition occurs in the cycle its pending clear is applied, the status bit stays set.
- R10: The enable bits, bit i matching status bit i, are written with the enable strobe. The interrupt equals the OR over bits of (status AND enable).
- R11: The transfer request is high exactly when the mode bit is 1 and the level is nonzero. With the mode bit at 0 it stays low.
- R12: Soft reset, sampled on a clock edge, returns the level, pointers, status, enables and read word to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous active-high lane reset |
| smp_valid | input | 1 | Sample write strobe |
| smp_data | input | 32 | Sample word |
| rd_en | input | 1 | Read strobe from the bus reader |
| rd_data | output | 32 | Last word read out |
| fill_lvl | output | 3 | Words currently held |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Write-one-to-clear mask |
| stat_q | output | 4 | Status: 0 full, 1 empty, 2 underflow, 3 overflow |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | New enable bits |
| en_q | output | 4 | Current enable bits |
| cfg_dma | input | 1 | 1 selects transfer-request mode |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | Transfer request |

## Verification
The level, the read word, and the full, empty, underflow and overflow status bits all change on the first edge after the stimulus. The same holds for the enable register. The bench therefore drives on a falling edge and checks on the next falling edge. A status clear takes effect two edges after it is driven, so the bench checks that the bit is still set one edge after the clear and gone one edge later. The interrupt and transfer request are combinational from registered state, so they are checked together with the level and status on the same sample. A model-driven push/pop sweep compares the level, the read word and the request on every cycle.

// File: rtl/smpl_fifo_pkg.sv
// Shared definitions for the per-lane sample buffer.
// Assumes status/enable vectors use the bit order given by evt_idx_e.
package smpl_fifo_pkg;
    localparam int EVT_W = 4;

    // Bit position of each event in the status and enable vectors.
    typedef enum int unsigned {
        EV_FULL  = 0,
        EV_EMPTY = 1,
        EV_UNDER = 2,
        EV_OVER  = 3
    } evt_idx_e;

    // Packed view: first member is the most significant bit.
    typedef struct packed {
        logic over;
        logic under;
        logic empty;
        logic full;
    } evt_t;
endpackage

// File: rtl/fifo_store.sv
// Circular word store with occupancy count and registered read port.
// Assumes DEPTH >= 2. Writes when full are dropped and reads when empty are
// ignored. Both attempts are reported as single-cycle pulses.
module fifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic          wr_drop,
    output logic          rd_miss,
    output logic          hit_full,
    output logic          hit_empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_nxt;
    logic [DW-1:0] rd_q;
    logic          full, empty, push, pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Decode occupancy flags and accepted transfers.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        push      = wr_req && !full;
        pop       = rd_req && !empty;
        wr_drop   = wr_req && full;
        rd_miss   = rd_req && empty;
        count_nxt = count + CW'(push) - CW'(pop);
        hit_full  = (count_nxt == CW'(DEPTH)) && !full;
        hit_empty = (count_nxt == '0) && !empty;
    end

    // Store an accepted sample at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers, count and the registered read word.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rd_q   <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
                rd_q   <= mem[rd_ptr];
            end
            count <= count_nxt;
        end
    end

    assign rd_data = rd_q;
    assign level   = count;
endmodule

// File: rtl/evt_status.sv
// Sticky event flags with write-one-to-clear applied one cycle late.
// Assumes event pulses are single-cycle. A new event beats a pending clear.
module evt_status
    import smpl_fifo_pkg::*;
#(
    parameter int NB = EVT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [NB-1:0] evt,
    input  logic          clr_we,
    input  logic [NB-1:0] clr_mask,
    output logic [NB-1:0] stat
);
    logic [NB-1:0] clr_pend;

    // Register the clear mask so it acts on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) clr_pend <= '0;
        else                    clr_pend <= clr_we ? clr_mask : '0;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bit
        logic bit_q;
        // Set on event, else drop when the pending clear hits this bit.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) bit_q <= 1'b0;
            else                    bit_q <= evt[b] | (bit_q & ~clr_pend[b]);
        end
        assign stat[b] = bit_q;
    end
endmodule

// File: rtl/req_gen.sv
// Enable register plus interrupt and transfer-request outputs.
// Assumes stat and level_nz come from registers, so outputs are glitch-safe.
module req_gen
    import smpl_fifo_pkg::*;
#(
    parameter int NB = EVT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          en_we,
    input  logic [NB-1:0] en_wdata,
    input  logic [NB-1:0] stat,
    input  logic          cfg_dma,
    input  logic          level_nz,
    output logic [NB-1:0] en_q,
    output logic          irq,
    output logic          dma_req
);
    // Hold the per-event enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) en_q <= '0;
        else if (en_we)         en_q <= en_wdata;
    end

    // Combine enabled flags and signal buffered data in transfer mode.
    always_comb begin
        irq     = |(stat & en_q);
        dma_req = cfg_dma && level_nz;
    end
endmodule

// File: rtl/smpl_chan_fifo.sv
// One sampling lane: word buffer, event status, enables and request outputs.
// Assumes a single clock. Both resets are synchronous.
module smpl_chan_fifo
    import smpl_fifo_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    output logic [LW-1:0]    fill_lvl,
    input  logic             clr_we,
    input  logic [EVT_W-1:0] clr_mask,
    output logic [EVT_W-1:0] stat_q,
    input  logic             en_we,
    input  logic [EVT_W-1:0] en_wdata,
    output logic [EVT_W-1:0] en_q,
    input  logic             cfg_dma,
    output logic             irq,
    output logic             dma_req
);
    logic wr_drop, rd_miss, hit_full, hit_empty;
    evt_t evt;

    fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_req(smp_valid), .wr_data(smp_data),
        .rd_req(rd_en), .rd_data(rd_data), .level(fill_lvl),
        .wr_drop(wr_drop), .rd_miss(rd_miss),
        .hit_full(hit_full), .hit_empty(hit_empty)
    );

    // Gather the store's event pulses into the status bit order.
    always_comb begin
        evt.full  = hit_full;
        evt.empty = hit_empty;
        evt.under = rd_miss;
        evt.over  = wr_drop;
    end

    evt_status #(.NB(EVT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .evt(evt), .clr_we(clr_we), .clr_mask(clr_mask), .stat(stat_q)
    );

    req_gen #(.NB(EVT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .en_we(en_we), .en_wdata(en_wdata), .stat(stat_q),
        .cfg_dma(cfg_dma), .level_nz(fill_lvl != '0),
        .en_q(en_q), .irq(irq), .dma_req(dma_req)
    );
endmodule

// File: rtl/smpl_chan_fifo_chk.sv
// Property checker for smpl_chan_fifo, attached by bind below.
module smpl_chan_fifo_chk #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          smp_valid,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [LW-1:0] fill_lvl,
    input logic [3:0]    stat_q,
    input logic [3:0]    en_q,
    input logic          cfg_dma,
    input logic          irq,
    input logic          dma_req
);
    a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        fill_lvl <= LW'(DEPTH));
    a_r4_over_flag: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (smp_valid && fill_lvl == LW'(DEPTH)) |=> stat_q[3]);
    a_r4_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (smp_valid && !rd_en && fill_lvl == LW'(DEPTH)) |=> fill_lvl == LW'(DEPTH));
    a_r5_under_flag: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (rd_en && fill_lvl == '0) |=> stat_q[2]);
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (rd_en && fill_lvl == '0) |=> $stable(rd_data));
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (en_q == '0) |-> !irq);
    a_r11_no_req_irq_mode: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !cfg_dma |-> !dma_req);
    a_r11_req_with_data: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (cfg_dma && fill_lvl != '0) |-> dma_req);
endmodule

bind smpl_chan_fifo smpl_chan_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .smp_valid(smp_valid), .rd_en(rd_en), .rd_data(rd_data),
    .fill_lvl(fill_lvl), .stat_q(stat_q), .en_q(en_q),
    .cfg_dma(cfg_dma), .irq(irq), .dma_req(dma_req)
);

// File: tb/smpl_chan_fifo_tb.sv
`timescale 1ns/1ps
module smpl_chan_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst = 1'b0;
    logic        smp_valid = 1'b0, rd_en = 1'b0;
    logic [31:0] smp_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  fill_lvl;
    logic        clr_we = 1'b0, en_we = 1'b0, cfg_dma = 1'b0;
    logic [3:0]  clr_mask = '0, en_wdata = '0, stat_q, en_q;
    logic        irq, dma_req;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    smpl_chan_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
        .rd_data(rd_data), .fill_lvl(fill_lvl),
        .clr_we(clr_we), .clr_mask(clr_mask), .stat_q(stat_q),
        .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
        .cfg_dma(cfg_dma), .irq(irq), .dma_req(dma_req)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic push_one(input logic [31:0] d);
        smp_valid = 1'b1; smp_data = d; tick(); smp_valid = 1'b0;
    endtask

    task automatic pop_one();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic clear_bits(input logic [3:0] m);
        clr_we = 1'b1; clr_mask = m; tick(); clr_we = 1'b0; clr_mask = '0; tick();
    endtask

    initial begin
        logic [31:0] arr [4];
        int wi, ri, cnt;
        logic [31:0] exp_rd;
        logic [15:0] lf;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 level", 32'(fill_lvl), 0);
        chk("R1 stat", 32'(stat_q), 0);
        chk("R1 en", 32'(en_q), 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq/req", {30'd0, irq, dma_req}, 0);

        // R3 R6 fill to capacity
        for (int i = 0; i < 4; i++) begin
            push_one(32'hA000_0000 + 32'(i));
            chk("R3 level on fill", 32'(fill_lvl), 32'(i + 1));
            chk("R6 full flag only at 4", 32'(stat_q[0]), (i == 3) ? 1 : 0);
        end
        // R4 overflow
        push_one(32'hDEAD_BEEF);
        chk("R4 level kept", 32'(fill_lvl), 4);
        chk("R4 over flag", 32'(stat_q[3]), 1);

        // R8 delayed clear of full bit
        clr_we = 1'b1; clr_mask = 4'b0001; tick(); clr_we = 1'b0; clr_mask = '0;
        chk("R8 not yet cleared", 32'(stat_q[0]), 1);
        tick();
        chk("R8 cleared", 32'(stat_q[0]), 0);
        chk("R8 other bit kept", 32'(stat_q[3]), 1);
        tick();
        chk("R6 no re-set while full", 32'(stat_q[0]), 0);

        // R9 event beats clear applied in same cycle
        clr_we = 1'b1; clr_mask = 4'b1000; tick(); clr_we = 1'b0; clr_mask = '0;
        push_one(32'h1111_1111);
        chk("R9 event wins", 32'(stat_q[3]), 1);
        clear_bits(4'b1000);
        chk("R8 over cleared", 32'(stat_q[3]), 0);

        // R2 drain in order, dropped word absent
        for (int i = 0; i < 4; i++) begin
            pop_one();
            chk("R2 order", rd_data, 32'hA000_0000 + 32'(i));
            chk("R3 level on drain", 32'(fill_lvl), 32'(3 - i));
            chk("R7 empty flag at 0", 32'(stat_q[1]), (i == 3) ? 1 : 0);
        end
        // R5 underflow
        pop_one();
        chk("R5 rd_data held", rd_data, 32'hA000_0003);
        chk("R5 level held", 32'(fill_lvl), 0);
        chk("R5 under flag", 32'(stat_q[2]), 1);

        // Build all four flags, then sweep enables (R10)
        for (int i = 0; i < 5; i++) push_one(32'h5000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) pop_one();
        chk("R10 all flags", 32'(stat_q), 32'hF);
        for (int e = 0; e < 16; e++) begin
            en_we = 1'b1; en_wdata = 4'(e); tick(); en_we = 1'b0;
            chk("R10 en write", 32'(en_q), 32'(e));
            chk("R10 irq all", 32'(irq), (e != 0) ? 1 : 0);
        end
        clear_bits(4'b1010);
        chk("R8 partial clear", 32'(stat_q), 32'h5);
        for (int e = 0; e < 16; e++) begin
            en_we = 1'b1; en_wdata = 4'(e); tick(); en_we = 1'b0;
            chk("R10 irq masked", 32'(irq), ((e & 5) != 0) ? 1 : 0);
        end

        // R11 transfer request
        push_one(32'h7777_0000);
        chk("R11 no req in irq mode", 32'(dma_req), 0);
        cfg_dma = 1'b1; #1;
        chk("R11 req with data", 32'(dma_req), 1);
        pop_one();
        chk("R11 req drops when drained", 32'(dma_req), 0);

        // R12 soft reset
        push_one(32'h2222_0000);
        push_one(32'h2222_0001);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk("R12 level", 32'(fill_lvl), 0);
        chk("R12 stat", 32'(stat_q), 0);
        chk("R12 en", 32'(en_q), 0);
        chk("R12 rd_data", rd_data, 0);
        chk("R12 irq/req", {30'd0, irq, dma_req}, 0);

        // Model-based push/pop sweep (R2 R3 R11)
        wi = 0; ri = 0; cnt = 0; exp_rd = '0; lf = 16'hACE1;
        for (int c = 0; c < 400; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            smp_valid = lf[0] | lf[7];
            rd_en     = lf[4] & ~(c > 200 && lf[9]);
            smp_data  = {lf, 16'(c)};
            if (rd_en && cnt > 0) begin exp_rd = arr[ri]; ri = (ri + 1) % 4; end
            if (smp_valid && cnt < 4) begin arr[wi] = smp_data; wi = (wi + 1) % 4; end
            cnt = cnt + ((smp_valid && cnt < 4) ? 1 : 0) - ((rd_en && cnt > 0) ? 1 : 0);
            tick();
            chk("R3 sweep level", 32'(fill_lvl), 32'(cnt));
            chk("R2 sweep data", rd_data, exp_rd);
            chk("R11 sweep req", 32'(dma_req), (cnt != 0) ? 1 : 0);
        end
        smp_valid = 1'b0; rd_en = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule